// File: doc/BRIEF.md
# Saturating multiply-accumulate unit

This block multiplies two 32-bit operands and folds the result into a 64-bit accumulator that is held as a high word and a low word. An operation is presented with a one-cycle `op_valid` strobe, together with a 4-bit operation code, a saturation-mode bit and two operands. The unit offers the following operations:

- clear the accumulator;
- load either half of the accumulator on its own;
- a 32x32 multiply that keeps only the low word;
- signed and unsigned 16x16 multiplies;
- signed and unsigned 32x32 multiplies that produce the full 64-bit product;
- 16x16 and 32x32 signed multiply-accumulate, each with an optional clamp.

When the clamp is on, the 16-bit accumulate works on the low word as a signed 32-bit value. If that value leaves the 32-bit range, it is pinned to the limit and the high word is set to 1 to mark the event. The 32-bit accumulate, when clamped, is pinned to the signed 48-bit range.

A small controller sequences every operation through a fixed pipeline. The states are IDLE, MULT, WRITE and DONE.

- In IDLE or DONE, a valid strobe is accepted (transition *accept*) and the controller moves to MULT.
- MULT registers the product (transition *product*) and moves to WRITE.
- WRITE updates the accumulator (transition *commit*) and moves to DONE.
- DONE raises `done` for one cycle. It then returns to IDLE (transition *retire*), or goes straight back to MULT if a new strobe arrives.

The `busy` output is high in MULT and WRITE, and strobes that arrive while it is high are dropped. The caller feeds operands it has already fetched and reads the result from the two accumulator outputs.

Top module: `smac_unit`

## Requirements
- R1: While reset is asserted and after it is released, both accumulator words read zero and `busy` and `done` are low.
- R2: A strobe that arrives while `busy` is low is accepted. `busy` is then high for the next two cycles, and `done` is high in the third cycle after acceptance, with the updated accumulator visible in that same cycle. A strobe that arrives while `busy` is high is ignored.
- R3: Code 0 (clear) sets all 64 accumulator bits to zero.
- R4: Code 1 writes the low 32 bits of the 32x32 product to the low word and keeps the high word.
- R5: Codes 2 (signed) and 3 (unsigned) multiply bits 15:0 of each operand. The operands are sign-extended for code 2 and zero-extended for code 3. The 32-bit product goes to the low word and the high word is kept.
- R6: Codes 4 (signed) and 5 (unsigned) write the full 64-bit product of the two 32-bit operands into {high, low}.
- R7: Code 6 with the mode bit at 0 adds the sign-extended signed 16x16 product to the whole 64-bit accumulator, with carries into the high word.
- R8: Code 6 with the mode bit at 1 adds the signed 16x16 product to the low word, taken as signed.
  - Above 0x7FFFFFFF, the result becomes high=1, low=0x7FFFFFFF.
  - Below -2^31, it becomes high=1, low=0x80000000.
  - Otherwise only the low word changes.
- R9: Code 7 adds the signed 32x32 product to the 64-bit accumulator, with wrap-around.
  - With the mode bit at 0, the wrapped sum is written as it is.
  - With the mode bit at 1, the sum is clamped to the range 0xFFFF800000000000 to 0x00007FFFFFFFFFFF.
- R10: Code 8 loads operand A into the high word and code 9 loads operand A into the low word. Each leaves the other word unchanged.
- R11: Codes 10 to 15 still raise `done` but leave both accumulator words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 4 | Operation code (see requirements) |
| sat_mode | input | 1 | Saturation mode bit for codes 6 and 7 |
| opnd_a | input | 32 | First operand, also the load value |
| opnd_b | input | 32 | Second operand |
| busy | output | 1 | High while an operation is in MULT or WRITE |
| done | output | 1 | One-cycle pulse when the accumulator has just been updated |
| acc_hi | output | 32 | High word of the accumulator |
| acc_lo | output | 32 | Low word of the accumulator |

## Verification
The 16-bit multiplies are driven with operands whose bit 15 is set, so sign extension and zero extension give different low words. The double-length multiply uses an all-ones operand, which separates the signed product from the unsigned one.

The clamped 16-bit accumulate is tried three ways: crossing the positive limit, crossing the negative limit, and staying in range with a nonzero high word, which shows that the high word is preserved only when the limits are not crossed. The unclamped 16-bit accumulate is started from a low word of all ones, so the carry into the high word becomes visible. The 32-bit accumulate uses a product above 2^48 with and without the clamp, and a large negative product, to reach both ends of the 48-bit range.

// File: rtl/smac_pkg.sv
package smac_pkg;

    typedef enum logic [3:0] {
        OP_CLEAR  = 4'd0,
        OP_MUL32  = 4'd1,
        OP_MULS16 = 4'd2,
        OP_MULU16 = 4'd3,
        OP_DMULS  = 4'd4,
        OP_DMULU  = 4'd5,
        OP_MAC16  = 4'd6,
        OP_MAC32  = 4'd7,
        OP_LDHI   = 4'd8,
        OP_LDLO   = 4'd9
    } smac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MULT  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } smac_state_e;

endpackage

// File: rtl/smac_ctrl.sv
module smac_ctrl
    import smac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    output logic accept,
    output logic prod_en,
    output logic commit,
    output logic busy,
    output logic done
);

    smac_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (op_valid) state_d = ST_MULT;
            ST_MULT:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = op_valid ? ST_MULT : ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        prod_en = 1'b0;
        commit  = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept = op_valid;
            ST_MULT:  begin prod_en = 1'b1; busy = 1'b1; end
            ST_WRITE: begin commit  = 1'b1; busy = 1'b1; end
            ST_DONE:  begin done = 1'b1; accept = op_valid; end
        endcase
    end

endmodule

// File: rtl/smac_mult.sv
module smac_mult
    import smac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              prod_en,
    input  logic [3:0]        op_in,
    input  logic              sat_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [3:0]        op_q,
    output logic              sat_q,
    output logic [DATA_W-1:0] a_q,
    output logic [ACC_W-1:0]  prod_q
);

    logic [3:0]        op_s1;
    logic              sat_s1;
    logic [DATA_W-1:0] opnd_s1 [2];
    logic [ACC_W-1:0]  opnd_x  [2];
    logic              narrow, signed_op;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_s1      <= OP_CLEAR;
            sat_s1     <= 1'b0;
            opnd_s1[0] <= '0;
            opnd_s1[1] <= '0;
        end else if (accept) begin
            op_s1      <= op_in;
            sat_s1     <= sat_in;
            opnd_s1[0] <= a_in;
            opnd_s1[1] <= b_in;
        end
    end

    always_comb begin
        narrow    = (op_s1 == OP_MULS16) || (op_s1 == OP_MULU16) || (op_s1 == OP_MAC16);
        signed_op = (op_s1 == OP_MULS16) || (op_s1 == OP_MAC16) ||
                    (op_s1 == OP_DMULS)  || (op_s1 == OP_MAC32);
    end

    for (genvar i = 0; i < 2; i++) begin : g_opnd
        always_comb begin
            if (narrow)
                opnd_x[i] = {{(ACC_W-HALF_W){signed_op & opnd_s1[i][HALF_W-1]}},
                             opnd_s1[i][HALF_W-1:0]};
            else
                opnd_x[i] = {{(ACC_W-DATA_W){signed_op & opnd_s1[i][DATA_W-1]}},
                             opnd_s1[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_CLEAR;
            sat_q  <= 1'b0;
            a_q    <= '0;
            prod_q <= '0;
        end else if (prod_en) begin
            op_q   <= op_s1;
            sat_q  <= sat_s1;
            a_q    <= opnd_s1[0];
            prod_q <= opnd_x[0] * opnd_x[1];
        end
    end

endmodule

// File: rtl/smac_accum.sv
module smac_accum
    import smac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SAT_W  = 48,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [3:0]        op_q,
    input  logic              sat_q,
    input  logic [DATA_W-1:0] a_q,
    input  logic [ACC_W-1:0]  prod_q,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo
);

    localparam logic [ACC_W-1:0]  WIDE_MAX = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic [ACC_W-1:0]  WIDE_MIN = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] LO_MAX   = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] LO_MIN   = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] SAT_MARK = DATA_W'(1);

    logic [DATA_W-1:0] hi_q, lo_q, hi_d, lo_d;
    logic [ACC_W-1:0]  acc, sum_full, clamp_full;
    logic [DATA_W:0]   lo_sum;
    logic              lo_pos, lo_neg, wide_fit;

    always_comb begin
        acc      = {hi_q, lo_q};
        sum_full = acc + prod_q;
        lo_sum   = {lo_q[DATA_W-1], lo_q} +
                   {prod_q[DATA_W-1], prod_q[DATA_W-1:0]};
        lo_pos   = !lo_sum[DATA_W] &&  lo_sum[DATA_W-1];
        lo_neg   =  lo_sum[DATA_W] && !lo_sum[DATA_W-1];
        wide_fit = (&sum_full[ACC_W-1:SAT_W-1]) || !(|sum_full[ACC_W-1:SAT_W-1]);
        clamp_full = wide_fit ? sum_full : (sum_full[ACC_W-1] ? WIDE_MIN : WIDE_MAX);
    end

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        unique case (op_q)
            OP_CLEAR:  begin hi_d = '0; lo_d = '0; end
            OP_MUL32,
            OP_MULS16,
            OP_MULU16: lo_d = prod_q[DATA_W-1:0];
            OP_DMULS,
            OP_DMULU:  {hi_d, lo_d} = prod_q;
            OP_MAC16: begin
                if (!sat_q)       {hi_d, lo_d} = sum_full;
                else if (lo_pos)  begin hi_d = SAT_MARK; lo_d = LO_MAX; end
                else if (lo_neg)  begin hi_d = SAT_MARK; lo_d = LO_MIN; end
                else              lo_d = lo_sum[DATA_W-1:0];
            end
            OP_MAC32:  {hi_d, lo_d} = sat_q ? clamp_full : sum_full;
            OP_LDHI:   hi_d = a_q;
            OP_LDLO:   lo_d = a_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (commit) begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign acc_hi = hi_q;
    assign acc_lo = lo_q;

endmodule

// File: rtl/smac_unit.sv
module smac_unit
    import smac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    parameter int SAT_W  = 48,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              sat_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo
);

    logic              accept, prod_en, commit;
    logic [3:0]        op_w;
    logic              sat_w;
    logic [DATA_W-1:0] a_w;
    logic [ACC_W-1:0]  prod_w;

    smac_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .accept   (accept),
        .prod_en  (prod_en),
        .commit   (commit),
        .busy     (busy),
        .done     (done)
    );

    smac_mult #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .prod_en (prod_en),
        .op_in   (op_code),
        .sat_in  (sat_mode),
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .op_q    (op_w),
        .sat_q   (sat_w),
        .a_q     (a_w),
        .prod_q  (prod_w)
    );

    smac_accum #(.DATA_W(DATA_W), .SAT_W(SAT_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .op_q   (op_w),
        .sat_q  (sat_w),
        .a_q    (a_w),
        .prod_q (prod_w),
        .acc_hi (acc_hi),
        .acc_lo (acc_lo)
    );

endmodule

// File: rtl/smac_checker.sv
module smac_checker #(
    parameter int DATA_W = 32,
    parameter int SAT_W  = 48,
    localparam int TOP_LO = SAT_W - 1 - DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] acc_hi,
    input logic [DATA_W-1:0] acc_lo,
    input logic [3:0]        op_q,
    input logic              sat_q
);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> busy);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |-> ##3 done);

    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({acc_hi, acc_lo}));

    p_keep_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == 4'd1 || op_q == 4'd2 || op_q == 4'd3 || op_q == 4'd9))
        |-> acc_hi == $past(acc_hi));

    p_sat16_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 4'd6 && sat_q)
        |-> (acc_hi == $past(acc_hi)) ||
            (acc_hi == DATA_W'(1) &&
             (acc_lo == {1'b0, {(DATA_W-1){1'b1}}} || acc_lo == {1'b1, {(DATA_W-1){1'b0}}})));

    p_sat48_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 4'd7 && sat_q)
        |-> ((&acc_hi[DATA_W-1:TOP_LO]) || !(|acc_hi[DATA_W-1:TOP_LO])));

    p_keep_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == 4'd8) |-> acc_lo == $past(acc_lo));

endmodule

bind smac_unit smac_checker #(.DATA_W(DATA_W), .SAT_W(SAT_W)) u_smac_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .busy     (busy),
    .done     (done),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo),
    .op_q     (op_w),
    .sat_q    (sat_w)
);

// File: tb/smac_unit_bench.sv
module smac_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        sat_mode = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        busy, done;
    logic [31:0] acc_hi, acc_lo;

    always #2 clk = ~clk;

    smac_unit u_smac_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .sat_mode (sat_mode),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .busy     (busy),
        .done     (done),
        .acc_hi   (acc_hi),
        .acc_lo   (acc_lo)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Reference model written from the requirements.
    task automatic model_step(input logic [3:0] op, input logic [31:0] a,
                              input logic [31:0] b, input logic s);
        longint p, t;
        case (op)
            4'd0: begin m_hi = '0; m_lo = '0; end
            4'd1: m_lo = a * b;
            4'd2: m_lo = 32'(int'(shortint'(a[15:0])) * int'(shortint'(b[15:0])));
            4'd3: m_lo = {16'h0, a[15:0]} * {16'h0, b[15:0]};
            4'd4: {m_hi, m_lo} = longint'(int'(a)) * longint'(int'(b));
            4'd5: {m_hi, m_lo} = {32'h0, a} * {32'h0, b};
            4'd6: begin
                p = longint'(int'(shortint'(a[15:0])) * int'(shortint'(b[15:0])));
                if (!s) {m_hi, m_lo} = {m_hi, m_lo} + p;
                else begin
                    t = longint'(int'(m_lo)) + p;
                    if (t > 64'sh7FFFFFFF)        begin m_hi = 32'd1; m_lo = 32'h7FFFFFFF; end
                    else if (t < -64'sh80000000) begin m_hi = 32'd1; m_lo = 32'h80000000; end
                    else m_lo = t[31:0];
                end
            end
            4'd7: begin
                t = longint'({m_hi, m_lo}) + longint'(int'(a)) * longint'(int'(b));
                if (s && t > 64'sh00007FFFFFFFFFFF) t = 64'sh00007FFFFFFFFFFF;
                else if (s && t < -64'sh0000800000000000) t = -64'sh0000800000000000;
                {m_hi, m_lo} = t;
            end
            4'd8: m_hi = a;
            4'd9: m_lo = a;
            default: ;
        endcase
    endtask

    task automatic drive(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic s, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; sat_mode = s;
        model_step(op, a, b, s);
        exp_q.push_back({m_hi, m_lo});
        tag_q.push_back(tag);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops one expectation per done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: unexpected done, actual %h expected none", {acc_hi, acc_lo});
            end else begin
                check(tag_q.pop_front(), {acc_hi, acc_lo}, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset acc", {acc_hi, acc_lo}, 64'h0);
        check("R1 reset flags", {62'h0, busy, done}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {acc_hi, acc_lo, 30'h0, busy, done}[63:0], 64'h0);

        // R10 individual loads
        drive(4'd8, 32'h12345678, 32'h0, 1'b0, "R10 load high");
        drive(4'd9, 32'h9ABCDEF0, 32'h0, 1'b0, "R10 load low");
        // R4 low multiply keeps high
        drive(4'd1, 32'h00010003, 32'h00020005, 1'b0, "R4 mul low");
        // R5 16-bit multiplies
        drive(4'd2, 32'hFFFF8000, 32'h00000002, 1'b0, "R5 signed 16");
        drive(4'd3, 32'hFFFF8000, 32'h00000002, 1'b0, "R5 unsigned 16");
        // R6 double-length
        drive(4'd4, 32'hFFFFFFFF, 32'h00000002, 1'b0, "R6 signed 64");
        drive(4'd5, 32'hFFFFFFFF, 32'h00000002, 1'b0, "R6 unsigned 64");
        // R3 clear
        drive(4'd0, 32'h0, 32'h0, 1'b0, "R3 clear");
        // R7 unclamped 16-bit accumulate carries into high
        drive(4'd9, 32'hFFFFFFFF, 32'h0, 1'b0, "R10 load low ones");
        drive(4'd6, 32'h00000001, 32'h00000001, 1'b0, "R7 mac16 carry");
        // R8 clamped 16-bit accumulate
        drive(4'd8, 32'h00000055, 32'h0, 1'b0, "R10 load high 55");
        drive(4'd9, 32'h7FFFFFF0, 32'h0, 1'b0, "R10 load low near max");
        drive(4'd6, 32'h00000020, 32'h00000001, 1'b1, "R8 positive clamp");
        drive(4'd9, 32'h80000005, 32'h0, 1'b0, "R10 load low near min");
        drive(4'd6, 32'h0000FFF0, 32'h00000001, 1'b1, "R8 negative clamp");
        drive(4'd8, 32'h00000055, 32'h0, 1'b0, "R10 reload high");
        drive(4'd9, 32'h0000000A, 32'h0, 1'b0, "R10 reload low");
        drive(4'd6, 32'h00000003, 32'h00000004, 1'b1, "R8 in range keeps high");
        // R9 32-bit accumulate
        drive(4'd0, 32'h0, 32'h0, 1'b0, "R3 clear again");
        drive(4'd7, 32'h40000000, 32'h40000000, 1'b0, "R9 mac32 unclamped");
        drive(4'd0, 32'h0, 32'h0, 1'b0, "R3 clear before clamp");
        drive(4'd7, 32'h40000000, 32'h40000000, 1'b1, "R9 mac32 clamp max");
        drive(4'd7, 32'h80000000, 32'h7FFFFFFF, 1'b1, "R9 mac32 clamp min");
        // R11 undefined code
        drive(4'd12, 32'hDEADBEEF, 32'h1, 1'b1, "R11 undefined code");
        drain();

        // R2 latency: drive by hand and count cycles
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd9; opnd_a = 32'hCAFE0001; opnd_b = '0; sat_mode = 1'b0;
        model_step(4'd9, 32'hCAFE0001, 32'h0, 1'b0);
        exp_q.push_back({m_hi, m_lo}); tag_q.push_back("R2 latency result");
        @(negedge clk); op_valid = 1'b0;
        check("R2 busy first cycle", {63'h0, busy}, 64'h1);
        @(negedge clk);
        check("R2 busy second cycle", {62'h0, busy, done}, 64'h2);
        @(negedge clk);
        check("R2 done third cycle", {62'h0, busy, done}, 64'h1);
        drain();

        // R2 strobe while busy is ignored
        drive(4'd1, 32'h00000007, 32'h00000003, 1'b0, "R2 op before ignored strobe");
        op_valid = 1'b1; op_code = 4'd0; opnd_a = '0; opnd_b = '0;
        @(negedge clk);
        op_valid = 1'b0;
        drain();
        check("R2 ignored clear", {acc_hi, acc_lo}, {m_hi, m_lo});

        report();
        $finish;
    end

endmodule